// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

This block is a small multicycle processor that keeps its program and its data in one external single-port memory. Each word is either an instruction or a data value depending only on which control step asks for it. A fixed sequence of control states fetches an instruction, decodes it and, for memory-touching operations, carries out one data access.

All memory traffic passes through two staging registers. An address register drives the memory address, and a data register captures words read back or holds the word to be written. A program counter steps through the program, and an accumulator keeps the result of every load and add.

The memory answers a read one clock after it sees the address. The block raises a halted flag when it meets a halt instruction and then freezes. The accumulator and program counter are visible on debug outputs.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the program counter and accumulator read zero, halted is low, the write enable is low and the memory address is zero.
- R2: An instruction is 16 bits, with the opcode in bits 15..12 and an address in bits 11..0. The opcodes are 0 = halt, 1 = load, 2 = add, 3 = store and 4 = jump.
- R3: During a fetch, the memory address equals the program counter. The counter rises by exactly one on the third rising edge of each instruction, and the memory returns a read one cycle after the address.
- R4: A load copies the memory word at the instruction's address into the accumulator.
- R5: An add sums the accumulator and the memory word at the instruction's address modulo 2^16, with no carry kept.
- R6: A store raises the write enable for exactly one cycle, with the instruction's address on the address port and the accumulator value on the write data port.
- R7: A jump loads the program counter with the instruction's address, and the next fetch reads that location.
- R8: A halt raises halted. Until the next reset, halted stays high, the counter, accumulator and address hold still, and no write happens.
- R9: Opcodes 5 to 15 do nothing except advance the program counter by one.
- R10: Code and data share one memory, so a word written by a store is later executed if the program counter reaches it.
- R11: Load, add and store take 7 cycles each, and every other instruction takes 4 cycles. A program of load, add, store and halt therefore raises halted on the 25th rising edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address, driven from the address staging register |
| mem_wdata | output | 16 | Memory write data, driven from the data staging register |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_acc | output | 16 | Accumulator value |
| dbg_pc | output | 12 | Program counter value |

## Verification
The bench builds the block with its default widths: a 16-bit word and a 4-bit opcode, which leave a 12-bit address. At these widths, adding 3 to 0xFFFF wraps to 0x0002 within one add, which tests the modulo rule. A stored jump word such as 0x4050 also reads directly as an executable instruction, which tests the shared code and data memory. The bench's memory model covers the low 1024 words, so jump targets and data can be placed well apart from the code.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  // Control sequencer states; every instruction walks a fixed path.
  typedef enum logic [2:0] {
    ST_FETCH_ADDR,
    ST_FETCH_READ,
    ST_FETCH_LATCH,
    ST_DECODE,
    ST_EXEC_ADDR,
    ST_EXEC_READ,
    ST_EXEC_DONE,
    ST_HALTED
  } cpu_state_e;

  // Decoded operation class (R2, R9).
  typedef enum logic [2:0] {
    K_HALT,
    K_LOAD,
    K_ADD,
    K_STORE,
    K_JUMP,
    K_NOP
  } op_kind_e;

  localparam int OPC_HALT  = 0;
  localparam int OPC_LOAD  = 1;
  localparam int OPC_ADD   = 2;
  localparam int OPC_STORE = 3;
  localparam int OPC_JUMP  = 4;

  // Map an opcode value to its class; anything undefined is a no-operation.
  function automatic op_kind_e op_classify(input int unsigned opc);
    op_kind_e k;
    case (opc)
      OPC_HALT:  k = K_HALT;
      OPC_LOAD:  k = K_LOAD;
      OPC_ADD:   k = K_ADD;
      OPC_STORE: k = K_STORE;
      OPC_JUMP:  k = K_JUMP;
      default:   k = K_NOP;
    endcase
    return k;
  endfunction

  // Operations that need a data access after decode.
  function automatic logic op_uses_memory(input op_kind_e k);
    return (k == K_LOAD) || (k == K_ADD) || (k == K_STORE);
  endfunction

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  op_kind_e   mdr_kind,
  input  op_kind_e   ir_kind,
  output cpu_state_e state_o,
  output logic       mar_from_pc,
  output logic       mar_from_ir,
  output logic       mdr_from_mem,
  output logic       mdr_from_acc,
  output logic       ir_from_mdr,
  output logic       pc_inc,
  output logic       pc_jump,
  output logic       acc_load,
  output logic       acc_add,
  output logic       mem_we,
  output logic       halted
);

  cpu_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH_ADDR;   // R1
    else     state_q <= state_d;
  end

  always_comb begin
    state_d      = state_q;
    mar_from_pc  = 1'b0;
    mar_from_ir  = 1'b0;
    mdr_from_mem = 1'b0;
    mdr_from_acc = 1'b0;
    ir_from_mdr  = 1'b0;
    pc_inc       = 1'b0;
    pc_jump      = 1'b0;
    acc_load     = 1'b0;
    acc_add      = 1'b0;
    mem_we       = 1'b0;
    halted       = 1'b0;
    case (state_q)
      ST_FETCH_ADDR: begin
        mar_from_pc = 1'b1;              // R3: counter onto the address bus
        state_d     = ST_FETCH_READ;
      end
      ST_FETCH_READ: begin
        state_d = ST_FETCH_LATCH;        // memory samples the address here
      end
      ST_FETCH_LATCH: begin
        mdr_from_mem = 1'b1;
        pc_inc       = 1'b1;             // R3: one step per fetch
        state_d      = ST_DECODE;
      end
      ST_DECODE: begin
        ir_from_mdr = 1'b1;
        case (mdr_kind)
          K_HALT: state_d = ST_HALTED;   // R8
          K_JUMP: begin
            pc_jump = 1'b1;              // R7
            state_d = ST_FETCH_ADDR;
          end
          default: state_d = op_uses_memory(mdr_kind) ? ST_EXEC_ADDR
                                                      : ST_FETCH_ADDR;  // R9
        endcase
      end
      ST_EXEC_ADDR: begin
        mar_from_ir  = 1'b1;
        mdr_from_acc = (ir_kind == K_STORE);
        state_d      = ST_EXEC_READ;
      end
      ST_EXEC_READ: begin
        mem_we  = (ir_kind == K_STORE);  // R6
        state_d = ST_EXEC_DONE;
      end
      ST_EXEC_DONE: begin
        mdr_from_mem = (ir_kind == K_LOAD) || (ir_kind == K_ADD);
        acc_load     = (ir_kind == K_LOAD);  // R4
        acc_add      = (ir_kind == K_ADD);   // R5
        state_d      = ST_FETCH_ADDR;
      end
      ST_HALTED: begin
        halted  = 1'b1;
        state_d = ST_HALTED;
      end
      default: state_d = ST_FETCH_ADDR;
    endcase
  end

  assign state_o = state_q;

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mar_from_pc,
  input  logic              mar_from_ir,
  input  logic              mdr_from_mem,
  input  logic              mdr_from_acc,
  input  logic              ir_from_mdr,
  input  logic              pc_inc,
  input  logic              pc_jump,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] acc_in,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q,
  output logic [DATA_W-1:0] ir_q
);

  // Address field of an instruction word (R2).
  function automatic logic [ADDR_W-1:0] addr_field(input logic [DATA_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  // Sequential successor, wrapping at the top of the address space.
  function automatic logic [ADDR_W-1:0] pc_succ(input logic [ADDR_W-1:0] p);
    return p + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (pc_jump)     pc_q <= addr_field(mdr_q);   // R7
      else if (pc_inc) pc_q <= pc_succ(pc_q);       // R3
      if (mar_from_pc)      mar_q <= pc_q;
      else if (mar_from_ir) mar_q <= addr_field(ir_q);
      if (mdr_from_mem)      mdr_q <= mem_rdata;
      else if (mdr_from_acc) mdr_q <= acc_in;       // R6
      if (ir_from_mdr) ir_q <= mdr_q;
    end
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_load,
  input  logic              acc_add,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc_q
);

  // Modulo 2^DATA_W sum, carry discarded (R5).
  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)           acc_q <= '0;
    else if (acc_load) acc_q <= operand;                 // R4
    else if (acc_add)  acc_q <= add_wrap(acc_q, operand);
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OPC_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [DATA_W-OPC_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic                     mem_we,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     halted,
  output logic [DATA_W-1:0]        dbg_acc,
  output logic [DATA_W-OPC_W-1:0]  dbg_pc
);

  localparam int ADDR_W = DATA_W - OPC_W;

  cpu_state_e        state;
  op_kind_e          mdr_kind, ir_kind;
  logic              mar_from_pc, mar_from_ir, mdr_from_mem, mdr_from_acc;
  logic              ir_from_mdr, pc_inc, pc_jump, acc_load, acc_add, we_c, halt_c;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, ir_q, acc_q;

  // Named events for the bound checker.
  logic              ev_fetch_read, ev_fetch_inc, ev_jump, ev_acc_load, ev_acc_add;
  logic [ADDR_W-1:0] jump_tgt;

  assign mdr_kind = op_classify(int'(mdr_q[DATA_W-1 -: OPC_W]));  // R2
  assign ir_kind  = op_classify(int'(ir_q[DATA_W-1 -: OPC_W]));

  acc_cpu_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .mdr_kind     (mdr_kind),
    .ir_kind      (ir_kind),
    .state_o      (state),
    .mar_from_pc  (mar_from_pc),
    .mar_from_ir  (mar_from_ir),
    .mdr_from_mem (mdr_from_mem),
    .mdr_from_acc (mdr_from_acc),
    .ir_from_mdr  (ir_from_mdr),
    .pc_inc       (pc_inc),
    .pc_jump      (pc_jump),
    .acc_load     (acc_load),
    .acc_add      (acc_add),
    .mem_we       (we_c),
    .halted       (halt_c)
  );

  acc_cpu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .mar_from_pc  (mar_from_pc),
    .mar_from_ir  (mar_from_ir),
    .mdr_from_mem (mdr_from_mem),
    .mdr_from_acc (mdr_from_acc),
    .ir_from_mdr  (ir_from_mdr),
    .pc_inc       (pc_inc),
    .pc_jump      (pc_jump),
    .mem_rdata    (mem_rdata),
    .acc_in       (acc_q),
    .pc_q         (pc_q),
    .mar_q        (mar_q),
    .mdr_q        (mdr_q),
    .ir_q         (ir_q)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .clk      (clk),
    .rst      (rst),
    .acc_load (acc_load),
    .acc_add  (acc_add),
    .operand  (mem_rdata),
    .acc_q    (acc_q)
  );

  assign ev_fetch_read = (state == ST_FETCH_READ);
  assign ev_fetch_inc  = pc_inc;
  assign ev_jump       = pc_jump;
  assign ev_acc_load   = acc_load;
  assign ev_acc_add    = acc_add;
  assign jump_tgt      = mdr_q[ADDR_W-1:0];

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_we    = we_c;
  assign halted    = halt_c;
  assign dbg_acc   = acc_q;
  assign dbg_pc    = pc_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              halted,
  input logic [ADDR_W-1:0] dbg_pc,
  input logic [DATA_W-1:0] dbg_acc,
  input logic              ev_fetch_read,
  input logic              ev_fetch_inc,
  input logic              ev_jump,
  input logic [ADDR_W-1:0] jump_tgt,
  input logic              ev_acc_load,
  input logic              ev_acc_add
);

  assert_fetch_addr_R3: assert property (@(posedge clk) disable iff (rst)
    ev_fetch_read |-> mem_addr == dbg_pc);

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
    ev_fetch_inc |=> dbg_pc == ADDR_W'($past(dbg_pc) + 1'b1));

  assert_acc_single_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_acc_load, ev_acc_add}));

  assert_store_data_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata == dbg_acc);

  assert_we_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
    ev_jump |=> dbg_pc == $past(jump_tgt));

  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(dbg_pc) && $stable(dbg_acc) && $stable(mem_addr));

  assert_halt_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .mem_we        (mem_we),
  .halted        (halted),
  .dbg_pc        (dbg_pc),
  .dbg_acc       (dbg_acc),
  .ev_fetch_read (ev_fetch_read),
  .ev_fetch_inc  (ev_fetch_inc),
  .ev_jump       (ev_jump),
  .jump_tgt      (jump_tgt),
  .ev_acc_load   (ev_acc_load),
  .ev_acc_add    (ev_acc_add)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

  localparam int DW = 16;
  localparam int AW = 12;
  localparam int MW = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          halted;
  logic [DW-1:0] dbg_acc;
  logic [AW-1:0] dbg_pc;

  logic          ld_en = 1'b0;
  logic [9:0]    ld_a  = '0;
  logic [DW-1:0] ld_d  = '0;
  logic [DW-1:0] mem [MW];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  string cur_req = "R6";

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
  wr_t exp_q[$];

  always #5 clk = ~clk;

  acc_cpu uut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .halted    (halted),
    .dbg_acc   (dbg_acc),
    .dbg_pc    (dbg_pc)
  );

  // Single-port memory, one cycle of read latency.
  always @(posedge clk) begin
    if (ld_en)       mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard driver side: record a write the program must make.
  task automatic expect_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_t w;
    w.a = a;
    w.d = d;
    exp_q.push_back(w);
  endtask

  // Scoreboard monitor side: every write is popped and compared.
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected write addr", 32'(mem_addr), 32'hFFFF_FFFF);
      end else begin
        wr_t w;
        w = exp_q.pop_front();
        chk(mem_addr == w.a, "R6", "write address", 32'(mem_addr), 32'(w.a));
        chk(mem_wdata == w.d, "R6", "write data", 32'(mem_wdata), 32'(w.d));
      end
    end
  end

  task automatic put(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_a  = 10'(a);
    ld_d  = d;
    ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MW; i++) put(i, 16'h0000);
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset falls, before any active edge.
    chk(dbg_pc == 0, "R1", "pc after reset", 32'(dbg_pc), 0);
    chk(dbg_acc == 0, "R1", "acc after reset", 32'(dbg_acc), 0);
    chk(!halted, "R1", "halted after reset", 32'(halted), 0);
    chk(!mem_we && mem_addr == 0, "R1", "bus after reset", 32'({mem_we, mem_addr}), 0);
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_halt(input int limit);
    int k;
    k = 0;
    while (!halted && k < limit) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    // ---------- Test A: load 12, add 23, store, halt (R4 R5 R6 R11 R2) ----------
    rst = 1'b1;
    clear_mem();
    put(0, 16'h1010);      // load  0x010
    put(1, 16'h2011);      // add   0x011
    put(2, 16'h3012);      // store 0x012
    put(3, 16'h0000);      // halt (opcode 0)
    put(16'h10, 16'd12);
    put(16'h11, 16'd23);
    expect_write(12'h012, 16'd35);
    chk(!halted, "R1", "halted during reset", 32'(halted), 0);
    release_rst();
    adv(2);
    chk(dbg_pc == 0, "R3", "pc before third edge", 32'(dbg_pc), 0);
    adv(1);
    chk(dbg_pc == 1, "R3", "pc after third edge", 32'(dbg_pc), 1);
    adv(4);                // edge 7: load finished
    chk(dbg_acc == 12, "R4", "acc after load", 32'(dbg_acc), 12);
    adv(7);                // edge 14: add finished
    chk(dbg_acc == 35, "R5", "acc after add", 32'(dbg_acc), 35);
    adv(10);               // edge 24
    chk(!halted, "R11", "halted before edge 25", 32'(halted), 0);
    adv(1);                // edge 25
    chk(halted, "R11", "halted at edge 25", 32'(halted), 1);
    chk(halted, "R2", "opcode 0 decodes as halt", 32'(halted), 1);
    chk(mem[16'h12] == 35, "R6", "stored sum", 32'(mem[16'h12]), 35);
    chk(dbg_pc == 4, "R8", "pc at halt", 32'(dbg_pc), 4);
    chk(exp_q.size() == 0, "R6", "writes outstanding", 32'(exp_q.size()), 0);

    // ---------- Test B: wrap, undefined opcode, jump (R5 R7 R9) ----------
    rst = 1'b1;
    cur_req = "R7";
    clear_mem();
    put(0, 16'h1020);      // load 0x020
    put(1, 16'h2021);      // add  0x021
    put(2, 16'h7ABC);      // undefined opcode 7
    put(3, 16'h4008);      // jump 0x008
    put(4, 16'h3022);      // store skipped by the jump
    put(8, 16'h3023);      // store 0x023
    put(9, 16'h0000);      // halt
    put(16'h20, 16'hFFFF);
    put(16'h21, 16'h0003);
    put(16'h22, 16'h5555);
    expect_write(12'h023, 16'h0002);
    release_rst();
    adv(7);
    chk(dbg_acc == 16'hFFFF, "R4", "acc after load FFFF", 32'(dbg_acc), 32'hFFFF);
    adv(7);                // edge 14
    chk(dbg_acc == 16'h0002, "R5", "wrapped sum", 32'(dbg_acc), 2);
    adv(4);                // edge 18: undefined opcode decoded
    chk(dbg_pc == 3, "R9", "pc after no-op", 32'(dbg_pc), 3);
    chk(dbg_acc == 16'h0002, "R9", "acc after no-op", 32'(dbg_acc), 2);
    adv(3);                // edge 21: jump fetched
    chk(dbg_pc == 4, "R7", "pc before jump decode", 32'(dbg_pc), 4);
    adv(1);                // edge 22: jump decoded
    chk(dbg_pc == 8, "R7", "pc after jump", 32'(dbg_pc), 8);
    wait_halt(200);
    chk(halted, "R8", "halted after program B", 32'(halted), 1);
    chk(dbg_pc == 10, "R7", "pc at halt after jump", 32'(dbg_pc), 10);
    chk(mem[16'h22] == 16'h5555, "R7", "skipped store left word", 32'(mem[16'h22]), 32'h5555);
    chk(mem[16'h23] == 16'h0002, "R6", "store after jump", 32'(mem[16'h23]), 2);

    // ---------- Test C: self-modifying code, halt freeze (R10 R8) ----------
    rst = 1'b1;
    cur_req = "R8";
    clear_mem();
    put(0, 16'h1030);      // load 0x030 (holds a jump word)
    put(1, 16'h3003);      // store into code address 3
    put(2, 16'hF000);      // undefined opcode 15
    put(3, 16'h0000);      // halt, replaced before it runs
    put(16'h30, 16'h4050); // jump 0x050 as data
    put(16'h50, 16'h0000); // halt
    expect_write(12'h003, 16'h4050);
    release_rst();
    wait_halt(200);
    chk(halted, "R10", "halted after rewritten code", 32'(halted), 1);
    chk(dbg_pc == 12'h051, "R10", "pc reached via stored jump", 32'(dbg_pc), 32'h51);
    chk(mem[3] == 16'h4050, "R10", "code word rewritten", 32'(mem[3]), 32'h4050);
    adv(20);
    chk(halted, "R8", "halted holds", 32'(halted), 1);
    chk(dbg_pc == 12'h051, "R8", "pc frozen", 32'(dbg_pc), 32'h51);
    chk(dbg_acc == 16'h4050, "R8", "acc frozen", 32'(dbg_acc), 32'h4050);
    chk(exp_q.size() == 0, "R8", "writes outstanding", 32'(exp_q.size()), 0);
    rst = 1'b1;
    adv(1);
    chk(!halted && dbg_pc == 0, "R1", "reset leaves halt", 32'({halted, dbg_pc}), 0);

    finish_up();
  end

endmodule